// File: doc/BRIEF.md
# Mel Filterbank Energy Accumulator

This block receives the complex spectrum of one analysis frame as a stream, one bin per accepted cycle, with markers on the first and final bin. For each bin it forms the power (real part squared plus imaginary part squared). The power is spread over a bank of overlapping triangular filters whose corner bins are evenly spaced on the mel scale. Each filter keeps a running energy total. The filter shapes are never evaluated at run time. A per-bin coefficient table is built at elaboration from the sample rate, the transform length, the upper band edge and the filter count. Each table word names the filter whose slope is rising at that bin and gives its weight. The filter just below receives the complementary weight.

When the final bin of a frame has passed through the pipeline, the block sends the whole set of filter energies as a burst on consecutive cycles, lowest filter first. While that burst is pending or under way it refuses new bins. A following stage (logarithm, cosine transform) takes the burst as its input.

Top module: `mel_energy_bank`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: The power of a bin is re·re + im·im, with `in_re` and `in_im` taken as signed two's-complement values of `IN_W` bits.
- R3: The edges are numbered e0…e(F+1) for F filters. e0 = 0 and e(F+1) = N·FHI/FS (integer). Each inner edge ej is floor(N·hz(j·M/(F+1))/FS), raised to e(j-1)+1 if it is not above it. Here M = mel(FHI), mel(f) = 1125·ln(1+f/700) and hz is the inverse of mel.
- R4: Bins are numbered from 0 at the bin carrying `in_start`. A bin k with ej ≤ k < e(j+1) has the weight w = floor(32768·(k−ej)/(e(j+1)−ej)), in unsigned Q1.15 with 32768 meaning 1.0. Filter j (0-based, if j < F) receives w, and filter j−1 (if j ≥ 1) receives 32768−w. Bins with k ≥ e(F+1) contribute nothing.
- R5: Each weighted contribution is floor(power·weight / 32768). A filter's energy is the sum of its contributions over the frame.
- R6: Each energy is an `ACC_W`-bit unsigned total that saturates at 2^ACC_W−1 and never wraps.
- R7: A bin carrying `in_start` discards all totals of any earlier unfinished frame. A new frame starts from zero plus that bin's contribution.
- R8: The F energies leave on F consecutive cycles, filter 0 first. `out_last` is set only with filter F−1. The first energy is valid in the cycle after the third rising edge that follows the edge accepting the `in_last` bin.
- R9: `in_ready` falls at the edge that accepts an `in_last` bin. It stays low until it rises in the cycle that presents filter F−1. Bins offered while it is low, including ones carrying `in_start`, change nothing.
- R10: `in_valid` may drop for any number of cycles inside a frame without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bin present on the input |
| in_start | input | 1 | Bin is bin 0 of a frame |
| in_last | input | 1 | Bin is the final bin of a frame |
| in_re | input | IN_W | Real part, signed |
| in_im | input | IN_W | Imaginary part, signed |
| in_ready | output | 1 | Block accepts a bin this cycle |
| out_valid | output | 1 | Energy present on the output |
| out_last | output | 1 | Energy belongs to the highest filter |
| out_energy | output | ACC_W | Filter energy, unsigned |

## Verification
A wrong coefficient word or a misaligned bin counter shows up as wrong energies on one pair of neighbouring filters. It appears in the burst of the same frame, three cycles after its final bin. A stale or wrapped total shows up as a value below the expected sum in that burst. An impulse on an edge bin isolates one table word per frame. A ready flag that rises too early, or a stray start marker accepted during the burst, shows up in the next burst as altered totals, or as `in_ready` high beside a non-final output.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

  localparam int W_W   = 16;
  localparam int UNITY = 1 << (W_W - 1);

  function automatic real hz_to_mel(input real f);
    return 1125.0 * $ln(1.0 + f / 700.0);
  endfunction

  function automatic real mel_to_hz(input real m);
    return 700.0 * ($exp(m / 1125.0) - 1.0);
  endfunction

  // Corner bin j of the filter bank (0 .. nf+1), forced strictly increasing.
  function automatic int edge_bin(input int j, input int nf, input int nfft,
                                  input int fs, input int fhi);
    real top;
    int  prev;
    int  cur;
    top  = hz_to_mel(real'(fhi));
    prev = 0;
    cur  = 0;
    for (int i = 1; i <= j; i++) begin
      if (i == nf + 1) begin
        cur = nfft * fhi / fs;
      end else begin
        cur = $rtoi(real'(nfft) * mel_to_hz(top * real'(i) / real'(nf + 1)) / real'(fs));
        if (cur <= prev) cur = prev + 1;
      end
      prev = cur;
    end
    return cur;
  endfunction

  // Coefficient word: [31] hit, [30:16] rising segment, [15:0] rising weight.
  function automatic logic [31:0] coef_word(input int k, input int nf, input int nfft,
                                            input int fs, input int fhi);
    int lo;
    int hi;
    int w;
    for (int j = 0; j <= nf; j++) begin
      lo = edge_bin(j, nf, nfft, fs, fhi);
      hi = edge_bin(j + 1, nf, nfft, fs, fhi);
      if (k >= lo && k < hi) begin
        w = (UNITY * (k - lo)) / (hi - lo);
        return {1'b1, 15'(j), 16'(w)};
      end
    end
    return '0;
  endfunction

endpackage

// File: rtl/mfb_coef_rom.sv
module mfb_coef_rom #(
  parameter int DEPTH = 128,
  parameter int N_FILT = 20,
  parameter int N_FFT = 256,
  parameter int FS_HZ = 8000,
  parameter int F_HI_HZ = 4000,
  parameter int AW = $clog2(DEPTH),
  parameter int SEG_W = $clog2(N_FILT + 1)
) (
  input  logic                     clk,
  input  logic [AW-1:0]            rd_addr,
  output logic                     q_hit,
  output logic [SEG_W-1:0]         q_seg,
  output logic [mfb_pkg::W_W-1:0]  q_w
);
  localparam int RW = 1 + SEG_W + mfb_pkg::W_W;

  logic [RW-1:0] table_w [DEPTH];
  logic [RW-1:0] q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    localparam logic [31:0] WORD = mfb_pkg::coef_word(k, N_FILT, N_FFT, FS_HZ, F_HI_HZ);
    assign table_w[k] = {WORD[31], WORD[16 +: SEG_W], WORD[15:0]};
  end

  always_ff @(posedge clk) begin
    q <= table_w[rd_addr];
  end

  assign q_hit = q[RW-1];
  assign q_seg = q[mfb_pkg::W_W +: SEG_W];
  assign q_w   = q[mfb_pkg::W_W-1:0];
endmodule

// File: rtl/mfb_power.sv
module mfb_power #(
  parameter int IN_W = 16,
  parameter int PW = 2 * IN_W
) (
  input  logic                   clk,
  input  logic signed [IN_W-1:0] re,
  input  logic signed [IN_W-1:0] im,
  output logic [PW-1:0]          pwr
);
  logic signed [2*IN_W-1:0] sq_re;
  logic signed [2*IN_W-1:0] sq_im;

  always_comb begin
    sq_re = re * re;
    sq_im = im * im;
  end

  always_ff @(posedge clk) begin
    pwr <= PW'(unsigned'(sq_re)) + PW'(unsigned'(sq_im));
  end
endmodule

// File: rtl/mfb_accum.sv
module mfb_accum #(
  parameter int N_FILT = 20,
  parameter int ACC_W = 48,
  parameter int PW = 32,
  parameter int SEG_W = $clog2(N_FILT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     clr,
  input  logic                     hit,
  input  logic [SEG_W-1:0]         seg,
  input  logic [mfb_pkg::W_W-1:0]  w,
  input  logic [PW-1:0]            pwr,
  output logic [ACC_W-1:0]         acc [N_FILT]
);
  localparam int WW     = mfb_pkg::W_W;
  localparam int PROD_W = PW + WW;
  localparam int SUM_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'({ACC_W{1'b1}});

  logic [WW-1:0]     w_fall;
  logic [PROD_W-1:0] rise_p;
  logic [PROD_W-1:0] fall_p;

  // Two shared multipliers: rising slope and falling slope of the bin.
  always_comb begin
    w_fall = WW'(mfb_pkg::UNITY) - w;
    rise_p = (PROD_W'(pwr) * PROD_W'(w)) >> (WW - 1);
    fall_p = (PROD_W'(pwr) * PROD_W'(w_fall)) >> (WW - 1);
  end

  for (genvar i = 0; i < N_FILT; i++) begin : g_filt
    logic [PROD_W-1:0] add;
    logic [SUM_W-1:0]  sum;

    always_comb begin
      if (hit && seg == SEG_W'(i))          add = rise_p;
      else if (hit && seg == SEG_W'(i + 1)) add = fall_p;
      else                                  add = '0;
      sum = (clr ? '0 : SUM_W'(acc[i])) + SUM_W'(add);
    end

    always_ff @(posedge clk) begin
      if (rst)     acc[i] <= '0;
      else if (en) acc[i] <= (sum > SAT) ? ACC_W'(SAT) : ACC_W'(sum);
    end

    // R6: within a frame a total never decreases.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (en && !clr) |=> (acc[i] >= $past(acc[i])));
  end
endmodule

// File: rtl/mel_energy_bank.sv
module mel_energy_bank #(
  parameter int IN_W = 16,
  parameter int N_FFT = 256,
  parameter int FS_HZ = 8000,
  parameter int F_HI_HZ = 4000,
  parameter int N_FILT = 20,
  parameter int ACC_W = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_start,
  input  logic                   in_last,
  input  logic signed [IN_W-1:0] in_re,
  input  logic signed [IN_W-1:0] in_im,
  output logic                   in_ready,
  output logic                   out_valid,
  output logic                   out_last,
  output logic [ACC_W-1:0]       out_energy
);
  localparam int DEPTH = N_FFT / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int SEG_W = $clog2(N_FILT + 1);
  localparam int FW    = $clog2(N_FILT);
  localparam int PW    = 2 * IN_W;
  localparam int WW    = mfb_pkg::W_W;

  logic accept;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx_now;
  logic oob_now;

  logic s1_valid, s1_start, s1_last, s1_oob;
  logic signed [IN_W-1:0] s1_re, s1_im;
  logic rom_hit;
  logic [SEG_W-1:0] rom_seg;
  logic [WW-1:0] rom_w;

  logic s2_valid, s2_start, s2_last, s2_hit;
  logic [SEG_W-1:0] s2_seg;
  logic [WW-1:0] s2_w;
  logic [PW-1:0] pwr;

  logic [ACC_W-1:0] acc [N_FILT];
  logic emit;
  logic [FW-1:0] oidx;

  assign accept  = in_valid && in_ready;
  assign idx_now = in_start ? '0 : cnt;
  assign oob_now = idx_now >= CW'(DEPTH);

  // Bin counter, saturating once past the table.
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (accept) begin
      if (in_start)              cnt <= CW'(1);
      else if (cnt != CW'(DEPTH)) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_start <= 1'b0;
      s1_last  <= 1'b0;
      s1_oob   <= 1'b0;
      s1_re    <= '0;
      s1_im    <= '0;
    end else begin
      s1_valid <= accept;
      s1_start <= in_start;
      s1_last  <= in_last;
      s1_oob   <= oob_now;
      s1_re    <= in_re;
      s1_im    <= in_im;
    end
  end

  mfb_coef_rom #(
    .DEPTH(DEPTH), .N_FILT(N_FILT), .N_FFT(N_FFT), .FS_HZ(FS_HZ),
    .F_HI_HZ(F_HI_HZ), .AW(AW), .SEG_W(SEG_W)
  ) u_rom (
    .clk(clk), .rd_addr(idx_now[AW-1:0]),
    .q_hit(rom_hit), .q_seg(rom_seg), .q_w(rom_w)
  );

  mfb_power #(.IN_W(IN_W), .PW(PW)) u_pwr (
    .clk(clk), .re(s1_re), .im(s1_im), .pwr(pwr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_start <= 1'b0;
      s2_last  <= 1'b0;
      s2_hit   <= 1'b0;
      s2_seg   <= '0;
      s2_w     <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_start <= s1_start;
      s2_last  <= s1_last;
      s2_hit   <= rom_hit && !s1_oob;
      s2_seg   <= rom_seg;
      s2_w     <= rom_w;
    end
  end

  mfb_accum #(.N_FILT(N_FILT), .ACC_W(ACC_W), .PW(PW), .SEG_W(SEG_W)) u_acc (
    .clk(clk), .rst(rst), .en(s2_valid), .clr(s2_start), .hit(s2_hit),
    .seg(s2_seg), .w(s2_w), .pwr(pwr), .acc(acc)
  );

  // Ready and output burst sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready   <= 1'b1;
      emit       <= 1'b0;
      oidx       <= '0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_energy <= '0;
    end else begin
      if (accept && in_last) in_ready <= 1'b0;
      if (emit) begin
        out_valid  <= 1'b1;
        out_energy <= acc[oidx];
        out_last   <= (oidx == FW'(N_FILT - 1));
        if (oidx == FW'(N_FILT - 1)) begin
          emit     <= 1'b0;
          in_ready <= 1'b1;
        end else begin
          oidx <= oidx + FW'(1);
        end
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
        if (s2_valid && s2_last) begin
          emit <= 1'b1;
          oidx <= '0;
        end
      end
    end
  end

  p_last_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  p_burst_unbroken_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);
  p_ready_low_burst_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> !in_ready);
  p_ready_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/mel_energy_bank_bench.sv
module mel_energy_bank_bench;
  localparam int IN_W = 16;
  localparam int NFFT = 256;
  localparam int FS = 8000;
  localparam int FHI = 4000;
  localparam int NF = 20;
  localparam int ACC_M = 48;
  localparam int ACC_S = 32;
  localparam int MAXB = 200;

  typedef struct {
    longint e;
    bit     l;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic signed [IN_W-1:0] in_re = '0, in_im = '0;
  logic rdy_m, ov_m, ol_m, rdy_s, ov_s, ol_s;
  logic [ACC_M-1:0] oe_m;
  logic [ACC_S-1:0] oe_s;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int last_acc = 0;
  int bidx_m = 0;
  int bidx_s = 0;
  int bnd [NF+2];
  int fre [MAXB];
  int fim [MAXB];
  bit [31:0] seed = 32'h1234_5678;
  item_t q_m [$];
  item_t q_s [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  mel_energy_bank #(.IN_W(IN_W), .N_FFT(NFFT), .FS_HZ(FS), .F_HI_HZ(FHI),
                    .N_FILT(NF), .ACC_W(ACC_M)) u_mel_energy_bank (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
    .in_re(in_re), .in_im(in_im), .in_ready(rdy_m), .out_valid(ov_m),
    .out_last(ol_m), .out_energy(oe_m));

  mel_energy_bank #(.IN_W(IN_W), .N_FFT(NFFT), .FS_HZ(FS), .F_HI_HZ(FHI),
                    .N_FILT(NF), .ACC_W(ACC_S)) u_mel_energy_bank_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
    .in_re(in_re), .in_im(in_im), .in_ready(rdy_s), .out_valid(ov_s),
    .out_last(ol_s), .out_energy(oe_s));

  function automatic real b_mel(input real f);
    return 1125.0 * $ln(1.0 + f / 700.0);
  endfunction
  function automatic real b_hz(input real m);
    return 700.0 * ($exp(m / 1125.0) - 1.0);
  endfunction

  // R3: corner bins from the mel spacing rule.
  task automatic make_bounds();
    real top;
    top = b_mel(real'(FHI));
    bnd[0] = 0;
    for (int j = 1; j <= NF + 1; j++) begin
      if (j == NF + 1) bnd[j] = NFFT * FHI / FS;
      else begin
        bnd[j] = $rtoi(real'(NFFT) * b_hz(top * real'(j) / real'(NF + 1)) / real'(FS));
        if (bnd[j] <= bnd[j-1]) bnd[j] = bnd[j-1] + 1;
      end
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]) - 32768;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Scoreboard entries from R2, R4, R5, R6.
  task automatic expect_frame(input int nb, input string tag);
    longint e [NF];
    longint p, w, mm, ms;
    int lo, hi, j;
    item_t it;
    for (int i = 0; i < NF; i++) e[i] = 0;
    for (int k = 0; k < nb; k++) begin
      if (k >= bnd[NF+1]) continue;
      j = 0;
      for (int s = 0; s <= NF; s++) if (k >= bnd[s] && k < bnd[s+1]) j = s;
      lo = bnd[j];
      hi = bnd[j+1];
      w = (longint'(32768) * (k - lo)) / (hi - lo);
      p = longint'(fre[k]) * fre[k] + longint'(fim[k]) * fim[k];
      if (j < NF) e[j] += (p * w) >>> 15;
      if (j >= 1) e[j-1] += (p * (32768 - w)) >>> 15;
    end
    mm = (longint'(1) <<< ACC_M) - 1;
    ms = (longint'(1) <<< ACC_S) - 1;
    for (int i = 0; i < NF; i++) begin
      it.l = (i == NF - 1);
      it.tag = tag;
      it.e = (e[i] > mm) ? mm : e[i];
      q_m.push_back(it);
      it.e = (e[i] > ms) ? ms : e[i];
      q_s.push_back(it);
    end
  endtask

  task automatic send_bins(input int nb, input bit with_last, input bit gaps, input bit junk);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      if (gaps && (k % 4 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
      while (!rdy_m) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_start = (k == 0);
      in_last  = with_last && (k == nb - 1);
      in_re    = IN_W'(fre[k]);
      in_im    = IN_W'(fim[k]);
      if (in_last) last_acc = cyc + 1;
    end
    @(negedge clk);
    if (junk) begin
      // R9: bins offered while ready is low must leave no trace.
      while (!rdy_m) begin
        in_valid = 1'b1;
        in_start = 1'b1;
        in_last  = 1'b0;
        in_re    = IN_W'(-32768);
        in_im    = IN_W'(-32768);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_start = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    while (q_m.size() != 0 || q_s.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    item_t it;
    if (!rst && ov_m) begin
      if (bidx_m == 0) check(cyc - last_acc == 3, "R8", "burst latency", cyc - last_acc, 3);
      if (q_m.size() == 0) check(1'b0, "R8", "unexpected output", longint'(oe_m), -1);
      else begin
        it = q_m.pop_front();
        check(longint'(oe_m) == it.e, it.tag, "energy", longint'(oe_m), it.e);
        check(ol_m == it.l, "R8", "last flag", ol_m, it.l);
      end
      if (!ol_m) check(!rdy_m, "R9", "ready during burst", rdy_m, 0);
      bidx_m = ol_m ? 0 : bidx_m + 1;
    end
  end

  always @(negedge clk) begin
    item_t it;
    if (!rst && ov_s) begin
      if (q_s.size() == 0) check(1'b0, "R6", "unexpected output", longint'(oe_s), -1);
      else begin
        it = q_s.pop_front();
        check(longint'(oe_s) == it.e, "R6", "narrow energy", longint'(oe_s), it.e);
        check(ol_s == it.l, "R8", "narrow last flag", ol_s, it.l);
      end
      bidx_s = ol_s ? 0 : bidx_s + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    make_bounds();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!ov_m && !ol_m, "R1", "outputs in reset", ov_m, 0);
    check(rdy_m, "R1", "ready in reset", rdy_m, 1);
    rst = 1'b0;
    @(negedge clk);
    check(!ov_m, "R1", "valid after reset", ov_m, 0);
    check(rdy_m && rdy_s, "R1", "ready after reset", rdy_m, 1);

    // R2 R5: constant spectrum, mixed signs.
    for (int k = 0; k < MAXB; k++) begin fre[k] = 100; fim[k] = -50; end
    expect_frame(129, "R5");
    send_bins(129, 1'b1, 1'b0, 1'b0);
    drain();

    // R4: ramp, bins past the top edge must not count.
    for (int k = 0; k < MAXB; k++) begin fre[k] = k * 37; fim[k] = k * 11 - 600; end
    expect_frame(160, "R4");
    send_bins(160, 1'b1, 1'b0, 1'b0);
    drain();

    // R10: random data with idle cycles inside the frame.
    for (int k = 0; k < MAXB; k++) begin fre[k] = rnd(); fim[k] = rnd(); end
    expect_frame(128, "R10");
    send_bins(128, 1'b1, 1'b1, 1'b0);
    drain();

    // R7: unfinished frame then a fresh start.
    for (int k = 0; k < MAXB; k++) begin fre[k] = 30000; fim[k] = 30000; end
    send_bins(40, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < MAXB; k++) begin fre[k] = rnd() / 4; fim[k] = rnd() / 4; end
    expect_frame(130, "R7");
    send_bins(130, 1'b1, 1'b0, 1'b0);
    drain();

    // R3: impulses on corner bins give full weight to one filter.
    for (int k = 0; k < MAXB; k++) begin fre[k] = 0; fim[k] = 0; end
    fre[bnd[1]] = 1000;
    fim[bnd[6]] = -2000;
    fre[bnd[NF]] = 3000;
    expect_frame(129, "R3");
    send_bins(129, 1'b1, 1'b0, 1'b0);
    drain();

    // R6 R9: full-scale frame, junk offered during the burst.
    for (int k = 0; k < MAXB; k++) begin fre[k] = -32768; fim[k] = -32768; end
    expect_frame(129, "R6");
    send_bins(129, 1'b1, 1'b0, 1'b1);
    drain();

    // R9: the junk must not have altered the following frame either.
    for (int k = 0; k < MAXB; k++) begin fre[k] = 7; fim[k] = 3; end
    expect_frame(129, "R9");
    send_bins(129, 1'b1, 1'b0, 1'b0);
    drain();

    check(q_m.size() == 0 && q_s.size() == 0, "R8", "queue empty", q_m.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule